// File: doc/BRIEF.md
# Random number generator control core

This block is the digital control and status logic that sits around a free-running entropy source. Serial seed bits arrive on a dedicated generator clock and are mixed into a 32-bit linear feedback shift register that runs only in that clock domain. After a fixed number of seed bits has been absorbed, the register contents are handed across to the bus clock domain and latched into a data register. Software then sees a data-ready indication and reads the word.

Two monitors run alongside the generator. A seed-pattern checker watches the raw bit stream for long runs of one value or long alternating stretches. A slow-clock detector counts bus cycles between generator clock activity. Each monitor drives a live status bit and a sticky flag. The two kinds of fault are handled differently. A seed fault discards the pending word and locks out further words until software clears the sticky flag and restarts the generator. A clock fault leaves the word already held intact, and delivery resumes once the clock is healthy again. One interrupt output combines data-ready and the two sticky flags under an interrupt-enable bit.

Top module: `rng_ctrl_core`

## Requirements
- R1: There are three word registers, selected by `bus_addr`. Address 0 is control: bit 0 is generator enable and bit 2 is interrupt enable. Address 1 is status: bit 0 is data ready, bit 1 is clock fault now, bit 2 is seed fault now, bit 4 is the sticky clock flag and bit 5 is the sticky seed flag. Address 2 is data, and address 3 reads as zero. Reads return data in the cycle after `bus_rd`. After reset every register reads 0 and `irq` is 0.
- R2: The shift register is 32 bits wide. On each generator clock while enabled it shifts left, and the new bit 0 is the seed bit XOR bits 31, 21, 1 and 0 of the old value. While the generator is disabled the register holds 0x00000001.
- R3: Each time 64 further seed bits have been shifted in, the value after the 64th shift is moved into the data register and data ready is set. No transfer takes place while the generator is disabled, while a seed fault is live, during the seed lockout, or while a clock fault is live.
- R4: `irq` is 1 exactly when interrupt enable is set and at least one of data ready, the sticky seed flag or the sticky clock flag is 1.
- R5: A read of the data register returns the held word and clears data ready.
- R6: A seed fault is live when more than 64 consecutive identical seed bits are seen, or when an alternating stretch is longer than 64 bits (more than 32 repetitions of 01). A run of exactly 64 of either kind raises no fault.
- R7: A live seed fault clears data ready and sets the sticky seed flag. Words stay locked out until the sticky seed flag has been cleared and enable has been written 0 and then 1.
- R8: The live clock fault is set when 16 bus cycles pass without any generator clock activity while enabled. It sets the sticky clock flag and clears itself when the clock returns.
- R9: A clock fault leaves data ready and the held word unchanged, and word delivery resumes after the fault clears.
- R10: A write whose `bus_wstrb` is not 4'b1111 changes no register.
- R11: Writing 0 to a sticky flag bit of the status register clears that flag. Writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| gen_clk | input | 1 | Dedicated generator clock |
| seed_bit | input | 1 | Serial entropy bit, sampled on `gen_clk` |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wstrb | input | 4 | Byte enables; only full-word writes take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every bus cycle, the local consequences of the register logic. It checks that a live seed fault drops data ready and sets its sticky flag, that a live clock fault sets its flag without dropping data ready, and that the lockout freezes the data register. It also checks that a data read clears data ready, that partial writes leave the control bits alone, and that the interrupt stays low without its enable. Only the bench scenarios can show behaviour that spans the two clock domains. These include the word values against an independent model of the shift register, the exact 64/65 boundaries of both seed-pattern detectors, the full lockout-and-restart sequence, and delivery resuming once a stopped generator clock starts again.

// File: rtl/rng_pkg.sv
package rng_pkg;
    localparam int BUS_W = 32;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_IRQ  = 2;

    localparam int STAT_READY     = 0;
    localparam int STAT_CLK_NOW   = 1;
    localparam int STAT_SEED_NOW  = 2;
    localparam int STAT_CLK_FLAG  = 4;
    localparam int STAT_SEED_FLAG = 5;
endpackage

// File: rtl/rng_sync2.sv
// Two-flop synchronizer for level or toggle signals entering a clock domain.
module rng_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_async;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_sync = st_q.s2;
endmodule

// File: rtl/rng_gen_domain.sv
// Generator-clock side: seed mixing, word counting, seed-pattern check,
// plus a free-running toggle that lets the bus side see this clock alive.
module rng_gen_domain #(
    parameter int               WIDTH          = 32,
    parameter int               SEEDS_PER_WORD = 64,
    parameter int               RUN_LIMIT      = 64,
    parameter int               ALT_LIMIT      = 64,
    parameter logic [WIDTH-1:0] TAPS           = 32'h8020_0003,
    parameter logic [WIDTH-1:0] INIT           = 32'h0000_0001
) (
    input  logic             gen_clk,
    input  logic             rst_n,
    input  logic             run_async,
    input  logic             seed_bit,
    output logic [WIDTH-1:0] word,
    output logic             word_tgl,
    output logic             beat_tgl,
    output logic             seed_bad
);
    localparam int CNT_W   = $clog2(SEEDS_PER_WORD);
    localparam int MAX_LIM = (RUN_LIMIT > ALT_LIMIT) ? RUN_LIMIT : ALT_LIMIT;
    localparam int LEN_W   = $clog2(MAX_LIM + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEEDS_PER_WORD - 1);
    localparam logic [LEN_W-1:0] RUN_CAP  = LEN_W'(RUN_LIMIT + 1);
    localparam logic [LEN_W-1:0] ALT_CAP  = LEN_W'(ALT_LIMIT + 1);

    typedef struct packed {
        logic [WIDTH-1:0] lfsr;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] snap;
        logic             wtgl;
        logic             btgl;
        logic             prev;
        logic [LEN_W-1:0] same_len;
        logic [LEN_W-1:0] alt_len;
        logic             bad;
    } gen_t;

    gen_t g_d, g_q;
    logic run_s;
    logic [WIDTH-1:0] shifted;

    rng_sync2 #(.W(1)) u_run_sync (
        .clk     (gen_clk),
        .rst_n   (rst_n),
        .d_async (run_async),
        .q_sync  (run_s)
    );

    always_comb begin
        g_d      = g_q;
        g_d.btgl = ~g_q.btgl;
        shifted  = {g_q.lfsr[WIDTH-2:0], (^(g_q.lfsr & TAPS)) ^ seed_bit};
        if (!run_s) begin
            g_d.lfsr     = INIT;
            g_d.cnt      = '0;
            g_d.prev     = 1'b0;
            g_d.same_len = '0;
            g_d.alt_len  = '0;
            g_d.bad      = 1'b0;
        end else begin
            g_d.lfsr = shifted;
            if (g_q.cnt == CNT_LAST) begin
                g_d.cnt  = '0;
                g_d.snap = shifted;
                g_d.wtgl = ~g_q.wtgl;
            end else begin
                g_d.cnt = g_q.cnt + CNT_W'(1);
            end
            if (seed_bit == g_q.prev) begin
                g_d.same_len = (g_q.same_len == RUN_CAP) ? RUN_CAP
                                                         : g_q.same_len + LEN_W'(1);
                g_d.alt_len  = LEN_W'(1);
            end else begin
                g_d.alt_len  = (g_q.alt_len == ALT_CAP) ? ALT_CAP
                                                        : g_q.alt_len + LEN_W'(1);
                g_d.same_len = LEN_W'(1);
            end
            g_d.prev = seed_bit;
            g_d.bad  = (g_d.same_len > LEN_W'(RUN_LIMIT)) ||
                       (g_d.alt_len  > LEN_W'(ALT_LIMIT));
        end
    end

    always_ff @(posedge gen_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q      <= '0;
            g_q.lfsr <= INIT;
        end else begin
            g_q <= g_d;
        end
    end

    assign word     = g_q.snap;
    assign word_tgl = g_q.wtgl;
    assign beat_tgl = g_q.btgl;
    assign seed_bad = g_q.bad;
endmodule

// File: rtl/rng_clk_monitor.sv
// Bus-clock side detector for a stalled or too-slow generator clock.
module rng_clk_monitor #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic beat_async,
    output logic slow
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] idle;
    } mon_t;

    mon_t m_d, m_q;
    logic beat_s;

    rng_sync2 #(.W(1)) u_beat_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (beat_async),
        .q_sync  (beat_s)
    );

    always_comb begin
        m_d      = m_q;
        m_d.prev = beat_s;
        if (!active || (beat_s != m_q.prev)) m_d.idle = '0;
        else if (m_q.idle != CAP)            m_d.idle = m_q.idle + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign slow = (m_q.idle == CAP);
endmodule

// File: rtl/rng_ctrl_core.sv
module rng_ctrl_core
    import rng_pkg::*;
#(
    parameter int          SEEDS_PER_WORD = 64,
    parameter int          RUN_LIMIT      = 64,
    parameter int          ALT_LIMIT      = 64,
    parameter int          CLK_LIMIT      = 16,
    parameter logic [31:0] TAPS           = 32'h8020_0003,
    parameter logic [31:0] INIT           = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gen_clk,
    input  logic        seed_bit,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_wstrb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    typedef struct packed {
        logic             run;
        logic             irq_en;
        logic             ready;
        logic             seed_flag;
        logic             clk_flag;
        logic             lock;
        logic             wprev;
        logic             irq;
        logic [BUS_W-1:0] data;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [BUS_W-1:0] gen_word;
    logic             gen_wtgl, gen_btgl, gen_bad;
    logic             wtgl_s, seed_now, clk_now;
    logic             word_pulse, load, full_wr;
    logic [BUS_W-1:0] stat_word, ctrl_word;

    rng_gen_domain #(
        .WIDTH          (BUS_W),
        .SEEDS_PER_WORD (SEEDS_PER_WORD),
        .RUN_LIMIT      (RUN_LIMIT),
        .ALT_LIMIT      (ALT_LIMIT),
        .TAPS           (TAPS),
        .INIT           (INIT)
    ) u_gen (
        .gen_clk   (gen_clk),
        .rst_n     (rst_n),
        .run_async (r_q.run),
        .seed_bit  (seed_bit),
        .word      (gen_word),
        .word_tgl  (gen_wtgl),
        .beat_tgl  (gen_btgl),
        .seed_bad  (gen_bad)
    );

    rng_sync2 #(.W(2)) u_evt_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({gen_wtgl, gen_bad}),
        .q_sync  ({wtgl_s, seed_now})
    );

    rng_clk_monitor #(.LIMIT(CLK_LIMIT)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (r_q.run),
        .beat_async (gen_btgl),
        .slow       (clk_now)
    );

    assign word_pulse = wtgl_s ^ r_q.wprev;
    assign load       = word_pulse && r_q.run && !r_q.lock && !seed_now && !clk_now;
    assign full_wr    = bus_wr && (bus_wstrb == 4'hF);

    always_comb begin
        stat_word = '0;
        stat_word[STAT_READY]     = r_q.ready;
        stat_word[STAT_CLK_NOW]   = clk_now;
        stat_word[STAT_SEED_NOW]  = seed_now;
        stat_word[STAT_CLK_FLAG]  = r_q.clk_flag;
        stat_word[STAT_SEED_FLAG] = r_q.seed_flag;
        ctrl_word = '0;
        ctrl_word[CTRL_RUN] = r_q.run;
        ctrl_word[CTRL_IRQ] = r_q.irq_en;
    end

    always_comb begin
        r_d       = r_q;
        r_d.wprev = wtgl_s;

        if (full_wr && bus_addr == ADDR_CTRL) begin
            r_d.run    = bus_wdata[CTRL_RUN];
            r_d.irq_en = bus_wdata[CTRL_IRQ];
        end
        if (full_wr && bus_addr == ADDR_STAT) begin
            r_d.seed_flag = r_q.seed_flag & bus_wdata[STAT_SEED_FLAG];
            r_d.clk_flag  = r_q.clk_flag  & bus_wdata[STAT_CLK_FLAG];
        end
        if (seed_now) r_d.seed_flag = 1'b1;
        if (clk_now)  r_d.clk_flag  = 1'b1;

        if (!r_q.run && !r_q.seed_flag) r_d.lock = 1'b0;
        if (seed_now)                   r_d.lock = 1'b1;

        if (bus_rd && bus_addr == ADDR_DATA) r_d.ready = 1'b0;
        if (load) begin
            r_d.data  = gen_word;
            r_d.ready = 1'b1;
        end
        if (seed_now) r_d.ready = 1'b0;

        if (bus_rd) begin
            case (bus_addr)
                ADDR_CTRL: r_d.rdata = ctrl_word;
                ADDR_STAT: r_d.rdata = stat_word;
                ADDR_DATA: r_d.rdata = r_q.data;
                default:   r_d.rdata = '0;
            endcase
        end

        r_d.irq = r_d.irq_en & (r_d.ready | r_d.seed_flag | r_d.clk_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.irq;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:6], bus_wdata[3], bus_wdata[1]};

    // Plain views of register state for the bound checker.
    logic             chk_run, chk_irq_en, chk_ready, chk_seed_flag, chk_clk_flag, chk_lock;
    logic [BUS_W-1:0] chk_data;
    assign chk_run       = r_q.run;
    assign chk_irq_en    = r_q.irq_en;
    assign chk_ready     = r_q.ready;
    assign chk_seed_flag = r_q.seed_flag;
    assign chk_clk_flag  = r_q.clk_flag;
    assign chk_lock      = r_q.lock;
    assign chk_data      = r_q.data;
endmodule

// File: rtl/rng_ctrl_core_chk.sv
module rng_ctrl_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [3:0]  bus_wstrb,
    input logic        run,
    input logic        irq_en,
    input logic        ready,
    input logic        seed_flag,
    input logic        clk_flag,
    input logic        lock,
    input logic [31:0] data,
    input logic        seed_now,
    input logic        clk_now,
    input logic        load,
    input logic        irq
);
    assert_seed_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_now |=> !ready);

    assert_seed_flag_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_now |=> seed_flag);

    assert_clk_flag_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_now |=> clk_flag);

    assert_lock_freezes_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(data));

    assert_clk_fault_keeps_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clk_now && !seed_now && !(bus_rd && bus_addr == 2'd2)) |=> ready);

    assert_partial_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wstrb != 4'hF) |=> ($stable(run) && $stable(irq_en)));

    assert_data_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && !load) |=> !ready);

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind rng_ctrl_core rng_ctrl_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wstrb (bus_wstrb),
    .run       (chk_run),
    .irq_en    (chk_irq_en),
    .ready     (chk_ready),
    .seed_flag (chk_seed_flag),
    .clk_flag  (chk_clk_flag),
    .lock      (chk_lock),
    .data      (chk_data),
    .seed_now  (seed_now),
    .clk_now   (clk_now),
    .load      (load),
    .irq       (irq)
);

// File: tb/tb_rng_ctrl_core.sv
`timescale 1ns/1ps
module tb_rng_ctrl_core;
    localparam logic [31:0] TAPS_M = 32'h8020_0003;

    logic        clk = 1'b0;
    logic        gen_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_bit = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_wstrb = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit gen_run = 1'b1;
    bit finished = 1'b0;

    bit seed_hist [0:65535];
    int edge_cnt = 0;
    bit force_buf [0:511];
    int force_len = 0;
    int force_pos = 0;
    int en_edge = 0;

    rng_ctrl_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_clk   (gen_clk),
        .seed_bit  (seed_bit),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wstrb (bus_wstrb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    initial begin
        #1;
        forever begin
            #6;
            if (gen_run) gen_clk = ~gen_clk;
        end
    end

    always @(posedge gen_clk) if (edge_cnt < 65535) edge_cnt <= edge_cnt + 1;

    always @(negedge gen_clk) begin
        bit b;
        if (force_pos < force_len) begin
            b = force_buf[force_pos];
            force_pos = force_pos + 1;
        end else begin
            b = 1'($urandom % 2);
        end
        seed_bit = b;
        seed_hist[edge_cnt] = b;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_ready(output bit got);
        logic [31:0] v;
        got = 1'b0;
        for (int i = 0; i < 500 && !got; i++) begin
            rd(2'd1, v);
            if (v[0]) got = 1'b1;
        end
    endtask

    task automatic enable(input logic [31:0] ctrl);
        wr(2'd0, ctrl, 4'hF);
        en_edge = edge_cnt;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_forced();
        while (force_pos < force_len) @(negedge clk);
        idle(30);
    endtask

    // Model of the shift register started at gen edge st: is v one of its word values?
    function automatic bit word_matches(logic [31:0] v, int st, int last);
        logic [31:0] s = 32'h1;
        if (st < 0) return 1'b0;
        for (int i = 0; (st + i) < last && i < 30000; i++) begin
            s = {s[30:0], (^(s & TAPS_M)) ^ seed_hist[st + i]};
            if (((i + 1) % 64) == 0 && s == v) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] last_word(int st, int last);
        logic [31:0] s = 32'h1;
        logic [31:0] w = 32'h1;
        for (int i = 0; (st + i) < last && i < 30000; i++) begin
            s = {s[30:0], (^(s & TAPS_M)) ^ seed_hist[st + i]};
            if (((i + 1) % 64) == 0) w = s;
        end
        return w;
    endfunction

    task automatic check_word(input logic [31:0] v, input string what);
        bit ok = 1'b0;
        for (int h = -2; h <= 4; h++) ok |= word_matches(v, en_edge + h, edge_cnt);
        chk(ok, "R2", what, v, last_word(en_edge + 1, edge_cnt));
    endtask

    task automatic force_bit(input bit b);
        force_buf[force_len] = b;
        force_len++;
    endtask

    task automatic new_force();
        force_len = 0;
        force_pos = 0;
    endtask

    initial begin
        logic [31:0] v, prev_w;
        bit got;
        void'($urandom(32'd4242));

        idle(5);
        rst_n = 1'b1;
        idle(3);

        // R1: reset values
        rd(2'd0, v); chk(v == 32'h0, "R1", "control after reset", v, 32'h0);
        rd(2'd1, v); chk(v == 32'h0, "R1", "status after reset", v, 32'h0);
        rd(2'd2, v); chk(v == 32'h0, "R1", "data after reset", v, 32'h0);
        rd(2'd3, v); chk(v == 32'h0, "R1", "unused address", v, 32'h0);
        chk(irq == 1'b0, "R4", "irq after reset", 32'(irq), 32'h0);

        // R3: first word after enable, with interrupt enabled
        enable(32'h5);
        rd(2'd0, v); chk(v == 32'h5, "R1", "control readback", v, 32'h5);
        wait_ready(got);
        chk(got, "R3", "data ready after 64 seeds", 32'(got), 32'h1);
        chk(irq == 1'b1, "R4", "irq on data ready", 32'(irq), 32'h1);
        rd(2'd2, v);
        check_word(v, "first word");
        prev_w = v;
        rd(2'd1, v); chk(v[0] == 1'b0, "R5", "ready cleared by data read", v, 32'h0);
        chk(irq == 1'b0, "R4", "irq low once ready cleared", 32'(irq), 32'h0);

        // R2/R3: several random words
        for (int n = 0; n < 4; n++) begin
            wait_ready(got);
            chk(got, "R3", "next word ready", 32'(got), 32'h1);
            rd(2'd2, v);
            check_word(v, "random word");
            chk(v != prev_w, "R3", "consecutive words differ", v, ~prev_w);
            prev_w = v;
        end

        // R10: partial write ignored
        wr(2'd0, 32'h0, 4'h3);
        rd(2'd0, v); chk(v == 32'h5, "R10", "partial control write", v, 32'h5);

        // R4: interrupt disabled
        wr(2'd0, 32'h1, 4'hF);
        wait_ready(got);
        chk(irq == 1'b0, "R4", "no irq without enable", 32'(irq), 32'h0);
        wr(2'd0, 32'h5, 4'hF);

        // R8/R9: clock stall
        rd(2'd2, v);
        wait_ready(got);
        gen_run = 1'b0;
        idle(60);
        rd(2'd1, v); chk(v == 32'h13, "R8", "status while clock stalled", v, 32'h13);
        chk(irq == 1'b1, "R4", "irq on clock flag", 32'(irq), 32'h1);
        rd(2'd2, v);
        check_word(v, "word held through clock fault R9");
        gen_run = 1'b1;
        idle(30);
        rd(2'd1, v); chk((v & 32'h16) == 32'h10, "R8", "live clock fault clears, flag sticks", v, 32'h10);
        wr(2'd1, 32'hFFFF_FFFF, 4'hF);
        rd(2'd1, v); chk(v[4] == 1'b1, "R11", "writing 1 keeps flag", v, 32'h10);
        wr(2'd1, 32'h0, 4'hF);
        rd(2'd1, v); chk((v & 32'h36) == 32'h0, "R11", "writing 0 clears flag", v, 32'h0);
        wait_ready(got);
        chk(got, "R9", "delivery resumes after clock fault", 32'(got), 32'h1);
        rd(2'd2, v);
        check_word(v, "word after clock fault");

        // R6: exactly 64 identical bits, then exactly 64 alternating bits
        new_force();
        force_bit(1'b1);
        for (int i = 0; i < 64; i++) force_bit(1'b0);
        force_bit(1'b1);
        force_bit(1'b0); force_bit(1'b0);
        for (int i = 0; i < 63; i++) force_bit((i % 2) == 0);
        force_bit(1'b1);
        wait_forced();
        rd(2'd1, v); chk((v & 32'h24) == 32'h0, "R6", "64-bit runs raise no fault", v, 32'h0);

        // R6: 65 alternating bits
        new_force();
        force_bit(1'b0); force_bit(1'b0);
        for (int i = 0; i < 64; i++) force_bit((i % 2) == 0);
        force_bit(1'b0);
        wait_forced();
        rd(2'd1, v); chk(v[5] == 1'b1, "R6", "65 alternating bits flagged", v, 32'h20);
        wr(2'd1, 32'h0, 4'hF);
        wr(2'd0, 32'h4, 4'hF);
        idle(20);
        enable(32'h5);
        wait_ready(got);
        rd(2'd2, v);

        // R6/R7: long constant run
        wait_ready(got);
        new_force();
        force_bit(1'b1);
        for (int i = 0; i < 100; i++) force_bit(1'b0);
        got = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            rd(2'd1, v);
            if (v[2]) got = 1'b1;
        end
        chk(got, "R6", "live seed fault on constant run", 32'(got), 32'h1);
        wait_forced();
        rd(2'd1, v); chk((v & 32'h25) == 32'h20, "R7", "ready dropped, seed flag set", v, 32'h20);
        chk(irq == 1'b1, "R4", "irq on seed flag", 32'(irq), 32'h1);
        idle(800);
        rd(2'd1, v); chk(v[0] == 1'b0, "R7", "no words during lockout", v, 32'h20);
        wr(2'd1, 32'h0, 4'hF);
        rd(2'd1, v); chk(v[5] == 1'b0, "R11", "seed flag cleared", v, 32'h0);
        idle(800);
        rd(2'd1, v); chk(v[0] == 1'b0, "R7", "still locked until restart", v, 32'h0);
        wr(2'd0, 32'h4, 4'hF);
        idle(20);
        enable(32'h5);
        wait_ready(got);
        chk(got, "R7", "words resume after restart", 32'(got), 32'h1);
        rd(2'd2, v);
        check_word(v, "word after restart");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule